// File: doc/BRIEF.md
# Frame-Synchronised Serial Word Receiver

This block takes a serial bit stream with its own serial clock and frame sync, assembles one word per frame, and hands the finished word to a holding register. The host reads that register at leisure. The serial clock, frame sync and data pins are oversampled by the system clock through synchronizer stages, and each data bit is taken at a falling edge of the serial clock.

The host selects the word length: 8, 12, 16 or 24 bits. It also selects the bit order (most significant first or least significant first) and the sync style. In level style the sync is held high for the whole word. In pulse style the sync lasts one serial-clock period just before the first bit. The block reports three conditions to the host: a word waiting in the holding register, a word lost because the previous one was never read, and an interrupt request. A sync that arrives in the middle of a word is not honoured. The partial word is dropped, and the block waits idle for the next sync.

Top module: `rxw_receiver`

## Requirements
- R1: After a synchronous reset, `rx_data_o` is zero and `rx_full_o`, `rx_ovr_o` and `rx_irq_o` are all low.
- R2: With `fs_bit_mode_i`=0, a rising frame sync seen at a serial-clock falling edge starts a word, and that edge carries its first bit. With `lsb_first_i`=0 the first bit is the word's most significant bit. The length codes on `wlen_sel_i` are 0 for 8 bits, 1 for 12, 2 for 16 and 3 for 24. The word appears right-aligned in `rx_data_o`, with the unused upper bits zero.
- R3: With `lsb_first_i`=1, the first received bit is bit 0 of the word and later bits fill upward.
- R4: With `fs_bit_mode_i`=1, a sync that is high at one falling edge makes the next falling edge carry bit 0. A sync pulse that coincides with the last bit of a word is legal, so the next word can follow with no gap.
- R5: When a word completes, `rx_full_o` goes high together with the new `rx_data_o`. A one-cycle pulse on `rd_data_i` clears `rx_full_o`.
- R6: `rx_irq_o` is high exactly when `rx_full_o` is high and `irq_en_i` is high.
- R7: If a word completes while `rx_full_o` is still high, `rx_ovr_o` is set and the new word replaces the old one in `rx_data_o`.
- R8: `rx_ovr_o` is cleared only by a `rd_stat_i` pulse followed later by a `rd_data_i` pulse. A data read with no status read before it leaves the flag set.
- R9: A sync seen in the middle of a word is not honoured. In level style that is a new rising sync. In pulse style it is a sync pulse before the last bit. The partial word is discarded and no transfer takes place. The next sync starts a new word normally.
- R10: While `rx_en_i` is low, no word is assembled and the holding register and flags do not change.
- R11: Idle gaps of any length between frames do not disturb reception.
- R12: Data is sampled only at falling serial-clock edges. Values on `ser_d_i` during the clock's high phase, or later in its low phase, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous, oversampled) |
| ser_fs_i | input | 1 | Frame sync |
| ser_d_i | input | 1 | Serial data |
| rx_en_i | input | 1 | Receiver enable |
| irq_en_i | input | 1 | Interrupt request enable |
| lsb_first_i | input | 1 | Bit order: 0 most significant first, 1 least significant first |
| wlen_sel_i | input | 2 | Word length code (0:8, 1:12, 2:16, 3:24) |
| fs_bit_mode_i | input | 1 | Sync style: 0 level for the word, 1 one-bit pulse |
| rd_data_i | input | 1 | One-cycle pulse: host read of the holding register |
| rd_stat_i | input | 1 | One-cycle pulse: host read of the status |
| rx_data_o | output | DATA_W | Holding register, word right-aligned |
| rx_full_o | output | 1 | Unread word present |
| rx_ovr_o | output | 1 | Word lost to overwrite |
| rx_irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a sync that lands inside a word. In level style the sync has to fall and rise again before the word ends. In pulse style a pulse has to come before the last bit, and a pulse on the last bit itself is legal, so the stimulus must hit bit positions exactly. The bench drives the serial clock bit by bit from tasks, so it chooses the exact bit at which the sync reappears. It then shows that no transfer happened and that the following sync yields a clean word. The overrun clear sequence is also exercised: a data read alone, then a status read followed by a data read.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    WL_8  = 2'd0,
    WL_12 = 2'd1,
    WL_16 = 2'd2,
    WL_24 = 2'd3
  } wlen_e;

  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (wlen_e'(code))
      WL_8:    return 8;
      WL_12:   return 12;
      WL_16:   return 16;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/rxw_sync.sv
module rxw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/rxw_shifter.sv
module rxw_shifter
  import rxw_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              fs_s,
  input  logic              d_s,
  input  logic              en,
  input  logic              lsb_first,
  input  logic [1:0]        wlen_sel,
  input  logic              bit_mode,
  output logic              word_done_o,
  output logic [DATA_W-1:0] word_o
);

  logic              sclk_q;
  logic              fs_prev;
  logic              busy;
  logic              pend;
  logic              lsb_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;

  logic              smp;
  logic              sync_ev;
  logic              last;
  logic              early;
  logic [LEN_W-1:0]  start_len;
  logic [LEN_W-1:0]  pos_first;
  logic [LEN_W-1:0]  pos_cur;
  logic [DATA_W-1:0] sr_nx;
  logic [DATA_W-1:0] sr_first;

  // falling edge of the synchronized serial clock
  assign smp       = sclk_q & ~sclk_s;
  assign sync_ev   = bit_mode ? fs_s : (fs_s & ~fs_prev);
  assign last      = busy && (cnt == len_q - LEN_W'(1));
  assign early     = busy && sync_ev && !(bit_mode && last);
  assign start_len = LEN_W'(wlen_bits(wlen_sel));
  assign pos_first = lsb_first ? '0 : (start_len - LEN_W'(1));
  assign pos_cur   = lsb_q ? cnt : (len_q - LEN_W'(1) - cnt);

  always_comb begin
    sr_nx          = sr;
    sr_nx[pos_cur] = d_s;
    sr_first            = '0;
    sr_first[pos_first] = d_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
    end
  end

  always_ff @(posedge clk) begin
    word_done_o <= 1'b0;
    if (rst) begin
      fs_prev <= 1'b1;
      busy    <= 1'b0;
      pend    <= 1'b0;
      lsb_q   <= 1'b0;
      len_q   <= LEN_W'(8);
      cnt     <= '0;
      sr      <= '0;
      word_o  <= '0;
    end else if (!en) begin
      fs_prev <= 1'b1;
      busy    <= 1'b0;
      pend    <= 1'b0;
    end else if (smp) begin
      fs_prev <= fs_s;
      if (early) begin
        busy <= 1'b0;
        pend <= 1'b0;
      end else if (busy) begin
        sr  <= sr_nx;
        cnt <= cnt + LEN_W'(1);
        if (last) begin
          busy        <= 1'b0;
          word_done_o <= 1'b1;
          word_o      <= sr_nx;
          pend        <= bit_mode && sync_ev;
        end
      end else if (pend || (sync_ev && !bit_mode)) begin
        pend  <= 1'b0;
        busy  <= 1'b1;
        cnt   <= LEN_W'(1);
        len_q <= start_len;
        lsb_q <= lsb_first;
        sr    <= sr_first;
      end else if (sync_ev) begin
        pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxw_holdreg.sv
module rxw_holdreg #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word,
  input  logic              irq_en,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              irq_o
);

  logic stat_seen;
  logic full_nx;
  logic lost;

  assign full_nx = word_done ? 1'b1 : (rd_data ? 1'b0 : full_o);
  assign lost    = word_done && full_o && !rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      full_o    <= 1'b0;
      ovr_o     <= 1'b0;
      irq_o     <= 1'b0;
      stat_seen <= 1'b0;
    end else begin
      full_o <= full_nx;
      irq_o  <= full_nx && irq_en;
      if (word_done) data_o <= word;
      if (lost) begin
        ovr_o     <= 1'b1;
        stat_seen <= 1'b0;
      end else if (rd_data && stat_seen) begin
        ovr_o     <= 1'b0;
        stat_seen <= 1'b0;
      end else if (rd_stat && ovr_o) begin
        stat_seen <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxw_receiver.sv
module rxw_receiver #(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_fs_i,
  input  logic              ser_d_i,
  input  logic              rx_en_i,
  input  logic              irq_en_i,
  input  logic              lsb_first_i,
  input  logic [1:0]        wlen_sel_i,
  input  logic              fs_bit_mode_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              rx_ovr_o,
  output logic              rx_irq_o
);

  localparam int LEN_W = $clog2(DATA_W + 1);

  logic [2:0]        pins_s;
  logic              word_done;
  logic [DATA_W-1:0] word;

  rxw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_clk_i, ser_fs_i, ser_d_i}),
    .sync_o  (pins_s)
  );

  rxw_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .sclk_s      (pins_s[2]),
    .fs_s        (pins_s[1]),
    .d_s         (pins_s[0]),
    .en          (rx_en_i),
    .lsb_first   (lsb_first_i),
    .wlen_sel    (wlen_sel_i),
    .bit_mode    (fs_bit_mode_i),
    .word_done_o (word_done),
    .word_o      (word)
  );

  rxw_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .word      (word),
    .irq_en    (irq_en_i),
    .rd_data   (rd_data_i),
    .rd_stat   (rd_stat_i),
    .data_o    (rx_data_o),
    .full_o    (rx_full_o),
    .ovr_o     (rx_ovr_o),
    .irq_o     (rx_irq_o)
  );

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en_i,
  input logic              rd_data_i,
  input logic              word_done,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              rx_ovr_o,
  input logic              rx_irq_o
);

  assert_irq_needs_full_R6: assert property (@(posedge clk) disable iff (rst)
    rx_irq_o |-> rx_full_o);

  assert_full_from_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full_o) |-> $past(word_done));

  assert_full_clear_by_read_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full_o) |-> $past(rd_data_i));

  assert_ovr_from_lost_word_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovr_o) |-> ($past(rx_full_o) && $past(word_done)));

  assert_ovr_clear_by_read_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ovr_o) |-> $past(rd_data_i));

  assert_data_held_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(word_done) |-> $stable(rx_data_o));

  assert_no_xfer_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(rx_en_i));

endmodule

bind rxw_receiver rxw_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en_i   (rx_en_i),
  .rd_data_i (rd_data_i),
  .word_done (word_done),
  .rx_data_o (rx_data_o),
  .rx_full_o (rx_full_o),
  .rx_ovr_o  (rx_ovr_o),
  .rx_irq_o  (rx_irq_o)
);

// File: tb/sim_rxw_receiver.sv
`timescale 1ns/1ps
module sim_rxw_receiver;

  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_clk = 1'b1, ser_fs = 1'b0, ser_d = 1'b0;
  logic          rx_en = 1'b0, irq_en = 1'b0, lsb_first = 1'b0, bit_mode = 1'b0;
  logic [1:0]    wlen = 2'd0;
  logic          rd_data = 1'b0, rd_stat = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_full, rx_ovr, rx_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rxw_receiver #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_fs_i(ser_fs), .ser_d_i(ser_d),
    .rx_en_i(rx_en), .irq_en_i(irq_en), .lsb_first_i(lsb_first), .wlen_sel_i(wlen),
    .fs_bit_mode_i(bit_mode), .rd_data_i(rd_data), .rd_stat_i(rd_stat),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .rx_ovr_o(rx_ovr), .rx_irq_o(rx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one serial bit: value valid only around the falling edge, garbage elsewhere
  task automatic sbit(input logic fs, input logic d);
    ser_clk = 1'b1; cyc(1);
    ser_fs = fs; ser_d = ~d; cyc(1);
    ser_d = d; cyc(4);
    ser_clk = 1'b0; cyc(4);
    ser_d = ~d; cyc(2);
  endtask

  function automatic int lenof(input logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 12 : (c == 2'd2) ? 16 : 24;
  endfunction

  function automatic logic stream_bit(input logic [DW-1:0] w, input int n, input int i, input logic lsb);
    return lsb ? w[i] : w[n-1-i];
  endfunction

  // level-style word, followed by an idle gap
  task automatic word_level(input logic [DW-1:0] w, input int gap);
    int n = lenof(wlen);
    for (int i = 0; i < n; i++) sbit(1'b1, stream_bit(w, n, i, lsb_first));
    for (int g = 0; g < gap; g++) sbit(1'b0, 1'b0);
    cyc(6);
  endtask

  // pulse-style word: sync bit then data bits; last bit may carry next sync
  task automatic word_pulse(input logic [DW-1:0] w, input logic lead, input logic sync_on_last);
    int n = lenof(wlen);
    if (lead) sbit(1'b1, 1'b0);
    for (int i = 0; i < n; i++)
      sbit((i == n-1) ? sync_on_last : 1'b0, stream_bit(w, n, i, lsb_first));
    cyc(6);
  endtask

  task automatic read_data();
    rd_data = 1'b1; cyc(1); rd_data = 1'b0; cyc(1);
  endtask

  task automatic read_stat();
    rd_stat = 1'b1; cyc(1); rd_stat = 1'b0; cyc(1);
  endtask

  function automatic logic [31:0] msk(input logic [DW-1:0] w, input int n);
    return 32'(w & ((DW'(1) << n) - DW'(1)));
  endfunction

  task automatic t_reset();
    check("R1 data", 32'(rx_data), 0);
    check("R1 full", 32'(rx_full), 0);
    check("R1 ovr", 32'(rx_ovr), 0);
    check("R1 irq", 32'(rx_irq), 0);
  endtask

  task automatic t_msb_lengths();
    logic [DW-1:0] pats [4] = '{24'hA5C3_96, 24'h5A3C_69, 24'hF0F0_0F, 24'h8001_7E};
    lsb_first = 1'b0; bit_mode = 1'b0;
    for (int c = 0; c < 4; c++) begin
      wlen = 2'(c);
      word_level(pats[c], 3 + 5*c);  // R11 varying gaps
      check("R2 msb-first word", 32'(rx_data), msk(pats[c], lenof(wlen)));
      check("R5 full set", 32'(rx_full), 1);
      read_data();
      check("R5 full cleared by read", 32'(rx_full), 0);
    end
    check("R11 no overrun across gaps", 32'(rx_ovr), 0);
  endtask

  task automatic t_lsb();
    lsb_first = 1'b1; bit_mode = 1'b0;
    wlen = 2'd2; word_level(24'h00_1234, 2);
    check("R3 lsb-first 16", 32'(rx_data), 32'h1234);
    read_data();
    wlen = 2'd1; word_level(24'h00_0A71, 2);
    check("R3 lsb-first 12", 32'(rx_data), 32'h0A71);
    read_data();
    lsb_first = 1'b0;
  endtask

  task automatic t_sample_edge();
    // sbit drives the inverse outside the falling-edge window
    wlen = 2'd0; bit_mode = 1'b0;
    word_level(24'h0000_C5, 1);
    check("R12 falling-edge sampling", 32'(rx_data), 32'hC5);
    read_data();
  endtask

  task automatic t_pulse();
    bit_mode = 1'b1; wlen = 2'd2;
    sbit(1'b0, 1'b0);
    word_pulse(24'h00_BEEF, 1'b1, 1'b0);
    check("R4 pulse-style word", 32'(rx_data), 32'hBEEF);
    read_data();
    wlen = 2'd0;
    word_pulse(24'h0000_3C, 1'b1, 1'b1);
    check("R4 first adjacent word", 32'(rx_data), 32'h3C);
    read_data();
    word_pulse(24'h0000_D2, 1'b0, 1'b0);
    check("R4 second adjacent word", 32'(rx_data), 32'hD2);
    check("R4 no overrun", 32'(rx_ovr), 0);
    read_data();
    bit_mode = 1'b0;
    sbit(1'b0, 1'b0);
  endtask

  task automatic t_irq();
    wlen = 2'd0; irq_en = 1'b1;
    word_level(24'h0000_11, 1);
    check("R6 irq with full", 32'(rx_irq), 1);
    read_data();
    check("R6 irq drops on read", 32'(rx_irq), 0);
    irq_en = 1'b0;
    word_level(24'h0000_22, 1);
    check("R6 irq masked", 32'(rx_irq), 0);
    read_data();
  endtask

  task automatic t_overrun();
    wlen = 2'd0;
    word_level(24'h0000_A1, 1);
    word_level(24'h0000_B2, 1);
    check("R7 overrun set", 32'(rx_ovr), 1);
    check("R7 newer word kept", 32'(rx_data), 32'hB2);
    read_data();
    check("R8 data read alone keeps ovr", 32'(rx_ovr), 1);
    read_stat();
    check("R8 status read alone keeps ovr", 32'(rx_ovr), 1);
    read_data();
    check("R8 status then data read clears", 32'(rx_ovr), 0);
  endtask

  task automatic t_early();
    logic [DW-1:0] w = 24'h00_C3A5;
    wlen = 2'd2; bit_mode = 1'b0;
    for (int i = 0; i < 5; i++) sbit(1'b1, stream_bit(w, 16, i, 1'b0));
    sbit(1'b0, 1'b0);
    for (int i = 0; i < 16; i++) sbit(1'b1, 1'b1);
    sbit(1'b0, 1'b0); cyc(6);
    check("R9 level early sync: no transfer", 32'(rx_full), 0);
    word_level(24'h00_6E19, 1);
    check("R9 level next sync clean", 32'(rx_data), 32'h6E19);
    read_data();
    bit_mode = 1'b1; wlen = 2'd0;
    sbit(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) sbit(1'b0, 1'b1);
    sbit(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) sbit(1'b0, 1'b1);
    cyc(6);
    check("R9 pulse early sync: no transfer", 32'(rx_full), 0);
    word_pulse(24'h0000_5B, 1'b1, 1'b0);
    check("R9 pulse next sync clean", 32'(rx_data), 32'h5B);
    read_data();
    bit_mode = 1'b0;
  endtask

  task automatic t_disabled();
    wlen = 2'd0; rx_en = 1'b0;
    word_level(24'h0000_77, 2);
    check("R10 disabled: full", 32'(rx_full), 0);
    check("R10 disabled: data", 32'(rx_data), 32'h5B);
    rx_en = 1'b1;
    sbit(1'b0, 1'b0);
    word_level(24'h0000_44, 1);
    check("R10 re-enabled word", 32'(rx_data), 32'h44);
    read_data();
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(2);
    t_reset();
    rx_en = 1'b1;
    sbit(1'b0, 1'b0);
    t_msb_lengths();
    t_lsb();
    t_sample_edge();
    t_pulse();
    t_irq();
    t_overrun();
    t_early();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule